// File: doc/BRIEF.md
# Two-Plane Hardware Cursor Line Overlay

This block lays a hardware cursor over one scanline of 24-bit pixels as they stream past. Each incoming pixel carries its screen column. For columns inside the cursor span, the block reads two pattern bytes from an external synchronous cursor memory and applies them to the pixel. One byte comes from a mask plane and one from an invert plane; the invert plane sits a fixed 128 bytes above the mask plane. Pixels outside the span, and every pixel while the cursor is off, pass through unchanged.

The cursor position, a left-edge pixel skip, the size select and the pattern base address of the current line are all supplied by surrounding logic. Vertical hit testing and line-address computation are not part of this block. Every pixel leaves the block exactly two clocks after it enters, whether or not the cursor touched it. The block accepts one pixel per clock with no stalls, and columns may arrive in any order and with gaps.

Top module: `hcur_overlay`

## Requirements
- R1: While reset is asserted and after it is released with no input, out_valid is 0 and out_rgb is 0.
- R2: A pixel presented with in_valid high in cycle t is output with out_valid high in cycle t+2, in the order of input. out_valid is low two cycles after in_valid is low. Gaps and arbitrary column order are allowed.
- R3: A pixel whose pattern index is at or beyond the cursor width is output unchanged. The pattern index is p = in_col - cur_x + cur_xoff.
- R4: With cur_en low, every pixel is output unchanged.
- R5: The cursor width is 64 pixels when cur_large is 1 and 32 pixels when it is 0.
- R6: For pattern index p, the mask byte is read at line_base + p/8 on pat_addr_a. The invert byte is read at that address + 128 on pat_addr_b. Both read ports have one clock of latency.
- R7: Within a byte, pattern bits are used MSB first: pattern index p uses bit 7 - (p mod 8).
- R8: Inside the span, a set invert-plane bit forces the pixel to 0x000000 first. A set mask-plane bit then inverts all 24 bits. Both bits set therefore gives 0xFFFFFF, the mask bit alone gives ~in_rgb, and neither bit gives in_rgb.
- R9: A column left of cur_x is output unchanged. cur_xoff skips the first cur_xoff pattern pixels, so column cur_x shows pattern index cur_xoff.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_en | input | 1 | Cursor enable |
| cur_large | input | 1 | 1 selects the 64-pixel cursor, 0 selects the 32-pixel cursor |
| cur_x | input | COL_W | Screen column of the cursor's left edge |
| cur_xoff | input | XOFF_W | Number of pattern pixels skipped at the left edge |
| line_base | input | ADDR_W | Mask-plane address of this line's first pattern byte |
| in_valid | input | 1 | Input pixel valid |
| in_col | input | COL_W | Screen column of the input pixel |
| in_rgb | input | 24 | Input pixel colour |
| pat_addr_a | output | ADDR_W | Mask-plane read address |
| pat_addr_b | output | ADDR_W | Invert-plane read address |
| pat_q_a | input | 8 | Mask-plane byte, one clock after its address |
| pat_q_b | input | 8 | Invert-plane byte, one clock after its address |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Output pixel colour |

## Verification
The hardest case to reach is a single pixel in which one specific combination of mask and invert bits meets a known colour. A pseudo-random pattern rarely lands all four combinations in one byte at a known bit order. The bench therefore writes one mask byte and one invert byte by hand so that each combination appears twice across a group of eight pixels. It then compares each output with a literal colour, which exposes errors in plane order, bit order and the black-then-invert rule. The left-edge skip is reached by placing the cursor at column zero with a nonzero skip, so that the first visible column must show a pattern bit from the middle of a byte.

// File: rtl/hcur_pkg.sv
package hcur_pkg;
  localparam int RGB_W   = 24;
  localparam int BYTE_W  = 8;
  localparam int BIT_W   = 3;

  // Pixel state held between address issue and pattern return
  typedef struct packed {
    logic             valid;
    logic             hit;
    logic [BIT_W-1:0] bit_sel;
    logic [RGB_W-1:0] rgb;
  } hc_stage_t;
endpackage

// File: rtl/hcur_span.sv
// Span test and pattern address generation for one pixel column.
module hcur_span #(
  parameter int COL_W     = 12,
  parameter int XOFF_W    = 6,
  parameter int ADDR_W    = 9,
  parameter int PLANE_GAP = 128,
  parameter int NARROW    = 32,
  parameter int WIDE      = 64
) (
  input  logic              cur_en,
  input  logic              cur_large,
  input  logic [COL_W-1:0]  cur_x,
  input  logic [XOFF_W-1:0] cur_xoff,
  input  logic [ADDR_W-1:0] line_base,
  input  logic [COL_W-1:0]  in_col,
  output logic              hit,
  output logic [2:0]        bit_sel,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b
);
  localparam int P_W = COL_W + 1;
  localparam int G_W = P_W - 3;

  logic [P_W-1:0] rel;
  logic [P_W-1:0] pidx;
  logic [P_W-1:0] span;
  logic [G_W-1:0] group;

  always_comb begin
    rel     = {1'b0, in_col} - {1'b0, cur_x};
    pidx    = rel + P_W'(cur_xoff);
    span    = cur_large ? P_W'(WIDE) : P_W'(NARROW);
    hit     = cur_en && (in_col >= cur_x) && (pidx < span);
    group   = pidx[P_W-1:3];
    bit_sel = pidx[2:0];
    addr_a  = line_base + ADDR_W'(group);
    addr_b  = addr_a + ADDR_W'(PLANE_GAP);
  end
endmodule

// File: rtl/hcur_mix.sv
// Applies the two pattern planes to one pixel and registers the result.
module hcur_mix
  import hcur_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  hc_stage_t         st,
  input  logic [BYTE_W-1:0] q_a,
  input  logic [BYTE_W-1:0] q_b,
  output logic              out_valid,
  output logic [RGB_W-1:0]  out_rgb
);
  logic [BIT_W-1:0] sh;
  logic             m_bit;
  logic             x_bit;
  logic [RGB_W-1:0] cleared;
  logic [RGB_W-1:0] mixed;

  always_comb begin
    sh      = BIT_W'(BYTE_W - 1) - st.bit_sel;   // MSB first
    m_bit   = st.hit && q_a[sh];
    x_bit   = st.hit && q_b[sh];
    cleared = x_bit ? '0 : st.rgb;
    mixed   = m_bit ? ~cleared : cleared;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= st.valid;
      out_rgb   <= mixed;
    end
  end
endmodule

// File: rtl/hcur_overlay.sv
module hcur_overlay
  import hcur_pkg::*;
#(
  parameter int COL_W     = 12,
  parameter int XOFF_W    = 6,
  parameter int ADDR_W    = 9,
  parameter int PLANE_GAP = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cur_en,
  input  logic              cur_large,
  input  logic [COL_W-1:0]  cur_x,
  input  logic [XOFF_W-1:0] cur_xoff,
  input  logic [ADDR_W-1:0] line_base,
  input  logic              in_valid,
  input  logic [COL_W-1:0]  in_col,
  input  logic [23:0]       in_rgb,
  output logic [ADDR_W-1:0] pat_addr_a,
  output logic [ADDR_W-1:0] pat_addr_b,
  input  logic [7:0]        pat_q_a,
  input  logic [7:0]        pat_q_b,
  output logic              out_valid,
  output logic [23:0]       out_rgb
);
  logic             hit_c;
  logic [2:0]       bit_c;
  hc_stage_t        st_q;

  hcur_span #(
    .COL_W(COL_W), .XOFF_W(XOFF_W), .ADDR_W(ADDR_W), .PLANE_GAP(PLANE_GAP)
  ) u_span (
    .cur_en(cur_en), .cur_large(cur_large), .cur_x(cur_x), .cur_xoff(cur_xoff),
    .line_base(line_base), .in_col(in_col), .hit(hit_c), .bit_sel(bit_c),
    .addr_a(pat_addr_a), .addr_b(pat_addr_b)
  );

  // Pixel waits here while the pattern memory returns its bytes
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      st_q.valid   <= in_valid;
      st_q.hit     <= in_valid && hit_c;
      st_q.bit_sel <= bit_c;
      st_q.rgb     <= in_rgb;
    end
  end

  hcur_mix u_mix (
    .clk(clk), .rst(rst), .st(st_q), .q_a(pat_q_a), .q_b(pat_q_b),
    .out_valid(out_valid), .out_rgb(out_rgb)
  );
endmodule

// File: rtl/hcur_checker.sv
module hcur_checker #(
  parameter int COL_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             cur_en,
  input logic [COL_W-1:0] cur_x,
  input logic             in_valid,
  input logic [COL_W-1:0] in_col,
  input logic [23:0]      in_rgb,
  input logic             out_valid,
  input logic [23:0]      out_rgb
);
  logic [1:0] age;
  logic       far;

  always_ff @(posedge clk) begin
    if (rst) age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  assign far = ({1'b0, in_col} >= ({1'b0, cur_x} + (COL_W+1)'(64)));

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R2

  AST_DISABLED_PASS: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && out_valid && $past(!cur_en, 2)) |-> (out_rgb == $past(in_rgb, 2))); // R4

  AST_LEFT_PASS: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && out_valid && $past(in_col < cur_x, 2)) |-> (out_rgb == $past(in_rgb, 2))); // R9

  AST_FAR_PASS: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2 && out_valid && $past(far, 2)) |-> (out_rgb == $past(in_rgb, 2))); // R3
endmodule

bind hcur_overlay hcur_checker #(.COL_W(COL_W)) u_hcur_chk (
  .clk(clk), .rst(rst), .cur_en(cur_en), .cur_x(cur_x), .in_valid(in_valid),
  .in_col(in_col), .in_rgb(in_rgb), .out_valid(out_valid), .out_rgb(out_rgb)
);

// File: tb/tb_hcur_overlay.sv
`timescale 1ns/1ps
module tb_hcur_overlay;
  localparam int COL_W = 12, XOFF_W = 6, ADDR_W = 9;

  logic clk = 0, rst = 1;
  logic cur_en = 0, cur_large = 0;
  logic [COL_W-1:0] cur_x = '0;
  logic [XOFF_W-1:0] cur_xoff = '0;
  logic [ADDR_W-1:0] line_base = '0;
  logic in_valid = 0;
  logic [COL_W-1:0] in_col = '0;
  logic [23:0] in_rgb = '0;
  logic [ADDR_W-1:0] pat_addr_a, pat_addr_b;
  logic [7:0] pat_q_a, pat_q_b;
  logic out_valid;
  logic [23:0] out_rgb;

  logic [7:0] cmem [0:(1<<ADDR_W)-1];
  logic [23:0] expq[$];
  string tagq[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0, mon_on = 0;

  always #5 clk = ~clk;

  hcur_overlay dut (
    .clk(clk), .rst(rst), .cur_en(cur_en), .cur_large(cur_large), .cur_x(cur_x),
    .cur_xoff(cur_xoff), .line_base(line_base), .in_valid(in_valid), .in_col(in_col),
    .in_rgb(in_rgb), .pat_addr_a(pat_addr_a), .pat_addr_b(pat_addr_b),
    .pat_q_a(pat_q_a), .pat_q_b(pat_q_b), .out_valid(out_valid), .out_rgb(out_rgb)
  );

  // Synchronous cursor memory, one clock read latency on each port
  always @(posedge clk) begin
    pat_q_a <= cmem[pat_addr_a];
    pat_q_b <= cmem[pat_addr_b];
  end

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  // Reference: pattern index, plane bytes, MSB-first bit, black then invert
  function automatic logic [23:0] model(input int col, input logic [23:0] rgb);
    int p, wid, sh;
    logic [7:0] a, b;
    logic [23:0] r;
    p   = col - int'(cur_x) + int'(cur_xoff);
    wid = cur_large ? 64 : 32;
    if (!cur_en || col < int'(cur_x) || p >= wid) return rgb;
    a  = cmem[int'(line_base) + p/8];
    b  = cmem[int'(line_base) + 128 + p/8];
    sh = 7 - (p % 8);
    r  = rgb;
    if (b[sh]) r = 24'h0;
    if (a[sh]) r = ~r;
    return r;
  endfunction

  function automatic logic [23:0] colour(input int col);
    return 24'(col * 40503 + 777);
  endfunction

  task automatic send(input int col, input logic [23:0] rgb, input logic [23:0] exp, input string req);
    @(negedge clk);
    in_valid = 1; in_col = COL_W'(col); in_rgb = rgb;
    expq.push_back(exp); tagq.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 0;
    end
  endtask

  task automatic setup(input bit en, input bit lg, input int x, input int xo, input int base);
    @(negedge clk);
    cur_en = en; cur_large = lg; cur_x = COL_W'(x); cur_xoff = XOFF_W'(xo);
    line_base = ADDR_W'(base);
  endtask

  // Monitor: R2 timing per cycle, pixel compare against queued expectation
  initial begin
    bit prev_v;
    logic [23:0] e;
    string t;
    prev_v = 0;
    forever begin
      @(posedge clk); #2;
      if (mon_on) begin
        check(out_valid === prev_v, "R2", {23'd0, out_valid}, {23'd0, prev_v});
        if (out_valid) begin
          if (expq.size() == 0) begin
            check(0, "R2", out_rgb, 24'hxxxxxx);
          end else begin
            e = expq.pop_front(); t = tagq.pop_front();
            check(out_rgb === e, t, out_rgb, e);
          end
        end
      end
      prev_v = in_valid;
    end
  end

  task automatic t_reset();
    rst = 1; idle(4);
    @(posedge clk); #2;
    check(out_valid === 1'b0, "R1", {23'd0, out_valid}, 24'd0);
    check(out_rgb === 24'd0, "R1", out_rgb, 24'd0);
    @(negedge clk); rst = 0;
    idle(3);
    @(posedge clk); #2;
    check(out_valid === 1'b0, "R1", {23'd0, out_valid}, 24'd0);
    mon_on = 1;
  endtask

  task automatic t_disabled();   // R4
    setup(0, 0, 40, 0, 16);
    for (int c = 30; c < 80; c++) send(c, colour(c), colour(c), "R4");
    idle(4);
  endtask

  task automatic t_narrow();     // R3 R5 R6 R7 R8 R9
    setup(1, 0, 40, 0, 16);
    for (int c = 30; c < 80; c++) send(c, colour(c), model(c, colour(c)), "R5");
    idle(4);
  endtask

  task automatic t_wide();       // R5 R3
    setup(1, 1, 100, 0, 32);
    for (int c = 90; c < 180; c++) send(c, colour(c), model(c, colour(c)), "R5");
    idle(4);
  endtask

  task automatic t_skip();       // R9
    setup(1, 0, 0, 13, 8);
    for (int c = 0; c < 26; c++) send(c, colour(c), model(c, colour(c)), "R9");
    idle(4);
  endtask

  task automatic t_rule();       // R6 R7 R8 with literal expectations
    cmem[64]  = 8'hF0;           // mask plane
    cmem[192] = 8'hCC;           // invert plane, 128 above
    setup(1, 0, 200, 0, 64);
    send(199, 24'h123456, 24'h123456, "R9");
    send(200, 24'h123456, 24'hFFFFFF, "R8");
    send(201, 24'h123456, 24'hFFFFFF, "R7");
    send(202, 24'h123456, 24'hEDCBA9, "R8");
    send(203, 24'h123456, 24'hEDCBA9, "R6");
    send(204, 24'h123456, 24'h000000, "R8");
    send(205, 24'h123456, 24'h000000, "R6");
    send(206, 24'h123456, 24'h123456, "R7");
    send(207, 24'h123456, 24'h123456, "R8");
    send(232, 24'h123456, 24'h123456, "R3");
    idle(4);
  endtask

  task automatic t_scatter();    // R2 out-of-order columns with gaps
    int cols[6] = '{71, 45, 40, 50, 10, 63};
    setup(1, 0, 40, 3, 16);
    foreach (cols[i]) begin
      send(cols[i], colour(cols[i]), model(cols[i], colour(cols[i])), "R2");
      idle(i % 3);
    end
    idle(4);
  endtask

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) cmem[i] = 8'((i * 73 + 19) ^ (i >> 3));
    t_reset();
    t_disabled();
    t_narrow();
    t_wide();
    t_skip();
    t_rule();
    t_scatter();
    check(expq.size() == 0, "R2", 24'(expq.size()), 24'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R2 actual=%06h expected=%06h", 24'd0, 24'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule